// File: doc/BRIEF.md
# Delta-Sigma Test Bit-Stream Generator

This block plays back a table of signed 24-bit samples, normally one period of a sine wave, and turns them into a single-bit delta-sigma stream with a matching bit clock. The stream either drives an external test DAC through a data line and a clock line, or is routed back inside the chip to stand in for modulator data. A setup agent loads the sample table through a simple write port, chooses how many entries are used, how long each entry is held, the bit rate, a bit-clock phase offset in eighths of a bit and a data delay in whole bits. It then raises the enable.

All timing comes from one eighth-of-a-bit tick. The tick is derived from the system clock by a programmable divider, and eight ticks make one bit. A sync pulse can restart playback at the first table entry when the sync-enable input allows it. This gives a known test-signal phase across many chips that receive the same sync.

Top module: `tbs_gen`

## Requirements
- R1: While `rst_n` is low or `en` is low, all four outputs are 0 and the pointer, hold count, modulator and delay line are cleared. Each rise of `en` therefore starts playback from entry 0.
- R2: Each new bit is produced by a first-order error-feedback loop on x, the signed top 16 bits of the current entry. With y the previous bit and F = 32768: acc := acc + x - (y ? F : -F), and the new bit is 1 exactly when acc >= 0. acc and y start at 0.
- R3: Each table entry is used for `hold_m1`+1 consecutive bits before the pointer moves to the next entry.
- R4: After the entry at index `tbl_last` has been used, the pointer wraps to index 0, so entries above `tbl_last` never affect the stream.
- R5: A one-cycle `sync` pulse while `sync_en` is 1 clears the pointer, the hold count and the modulator, so the bits that follow repeat the stream of a fresh start from its first bit.
- R6: A `sync` pulse while `sync_en` is 0 has no effect on the stream.
- R7: One eighth-bit tick lasts `rate_div`+1 system clocks, and one bit lasts 8 ticks. The bit clock is high during eighths 4 to 7 of each bit when the offset is 0, and a new data bit starts at eighth 0.
- R8: `clk_phase` = p delays the whole bit-clock waveform by p eighths (p = 0..7), while the data timing stays unchanged.
- R9: `data_dly` = d (0..63) delays the data line by d whole bits relative to the bit clock. The first d bits after enable are 0.
- R10: With `loop_en` = 1 the stream and clock appear only on `lb_data`/`lb_clk`, and `bs_data`/`bs_clk` stay 0. With `loop_en` = 0 it is the other way round.
- R11: A write with `wr_en` = 1 stores `wr_data` at `wr_addr`, and the stream that follows reflects the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; low holds the block idle |
| sync | input | 1 | One-cycle restart pulse |
| sync_en | input | 1 | Lets `sync` restart playback |
| loop_en | input | 1 | Routes the stream to the loopback outputs |
| clk_phase | input | 3 | Bit-clock offset in eighths of a bit |
| data_dly | input | 6 | Data delay in whole bits |
| rate_div | input | 16 | System clocks per eighth-bit tick, minus one |
| hold_m1 | input | 8 | Bits per table entry, minus one |
| tbl_last | input | 10 | Index of the last table entry used |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 10 | Table write index |
| wr_data | input | 24 | Table write sample, two's complement |
| bs_data | output | 1 | External stream data |
| bs_clk | output | 1 | External stream clock |
| lb_data | output | 1 | Loopback stream data |
| lb_clk | output | 1 | Loopback stream clock |

## Verification
All outputs are registered one system clock after the phase counter and the modulator. A data bit made at a bit boundary is therefore valid on the pins one clock later, and the bit clock rises one clock after the phase counter reaches eighth 4 plus the offset. The bench samples on the falling system-clock edge, detects each rise of the bit clock and reads the data line at that same sample. In that sample, rise number j after enable carries the bit made by the j-th update, delayed by `data_dly`. This pairing is fixed by the register count and does not depend on `rate_div`. Offset and period checks measure clock-rise times relative to the enable cycle and to each other, so the constant one-clock output lag cancels. Sync checks pulse `sync` on the sample right after a clock rise, before the next bit boundary, so the following rises must carry the fresh-start bits 1, 2, 3 and so on.

// File: rtl/tbs_pkg.sv
// Shared constants and helpers for the test bit-stream generator.
package tbs_pkg;
    localparam int EIGHTHS = 8;
    localparam int PH_W    = $clog2(EIGHTHS);

    typedef logic [PH_W-1:0] phase_t;

    // Bit-clock level for a given eighth index and offset: high in upper half.
    function automatic logic clk_level(input phase_t ph, input phase_t ofs);
        phase_t rel;
        rel = ph - ofs;
        return rel[PH_W-1];
    endfunction
endpackage

// File: rtl/tbs_tick.sv
// Eighth-bit tick divider and phase counter.
// Assumes: rate_div is held stable while en is high; en low clears the count.
module tbs_tick
    import tbs_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] rate_div,
    output phase_t           phase,
    output logic             bit_stb
);
    logic [DIV_W-1:0] div_cnt;
    logic             tick;

    assign tick    = en && (div_cnt == rate_div);
    assign bit_stb = tick && (phase == phase_t'(EIGHTHS - 1));

    // Count system clocks per eighth, then step the eighth index.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            div_cnt <= '0;
            phase   <= '0;
        end else if (tick) begin
            div_cnt <= '0;
            phase   <= phase + phase_t'(1);
        end else begin
            div_cnt <= div_cnt + DIV_W'(1);
        end
    end

    // R7: a bit boundary always returns the eighth index to zero
    a_r7_bit_wraps_phase: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> phase == '0);

    // R7: the eighth index moves only on a tick
    a_r7_phase_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        en && !tick |=> $stable(phase));
endmodule

// File: rtl/tbs_table.sv
// Sample table with hold counter and wrapping read pointer.
// Assumes: tbl_last < DEPTH; the table keeps its contents across reset.
module tbs_table #(
    parameter int SAMPLE_W = 24,
    parameter int DEPTH    = 1024,
    parameter int MOD_W    = 16,
    parameter int HOLD_W   = 8,
    localparam int ADDR_W  = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                bit_stb,
    input  logic                sync_clr,
    input  logic [ADDR_W-1:0]   tbl_last,
    input  logic [HOLD_W-1:0]   hold_m1,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [SAMPLE_W-1:0] wr_data,
    output logic [MOD_W-1:0]    sample_hi
);
    logic [SAMPLE_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0]   ptr;
    logic [HOLD_W-1:0]   hold_cnt;
    logic                last_bit;

    assign last_bit  = (hold_cnt >= hold_m1);
    assign sample_hi = mem[ptr][SAMPLE_W-1 -: MOD_W];

    // Store a sample from the write port.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Advance hold count per bit and the pointer per finished entry.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || sync_clr) begin
            ptr      <= '0;
            hold_cnt <= '0;
        end else if (bit_stb) begin
            if (last_bit) begin
                hold_cnt <= '0;
                ptr      <= (ptr >= tbl_last) ? '0 : ptr + ADDR_W'(1);
            end else begin
                hold_cnt <= hold_cnt + HOLD_W'(1);
            end
        end
    end

    // R3: between bit boundaries the pointer does not move
    a_r3_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        en && !sync_clr && !bit_stb |=> $stable(ptr));

    // R4: finishing the last programmed entry returns to entry 0
    a_r4_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        en && !sync_clr && bit_stb && last_bit && (ptr >= tbl_last) |=> ptr == '0);

    // R5: an allowed sync restarts at the first entry
    a_r5_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> (ptr == '0) && (hold_cnt == '0));
endmodule

// File: rtl/tbs_dsm.sv
// First-order error-feedback delta-sigma modulator, one update per bit.
// Assumes: input is two's complement; full scale maps to +/- 2^(MOD_W-1).
module tbs_dsm #(
    parameter int MOD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             stb,
    input  logic [MOD_W-1:0] sample_hi,
    output logic             bit_q
);
    localparam int ACC_W = MOD_W + 2;
    localparam logic signed [ACC_W-1:0] FULL     = ACC_W'(1) <<< (MOD_W - 1);
    localparam logic signed [ACC_W-1:0] TWO_FULL = ACC_W'(1) <<< MOD_W;

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] fb;
    logic signed [ACC_W-1:0] acc_nxt;

    assign x_ext   = {{(ACC_W - MOD_W){sample_hi[MOD_W-1]}}, sample_hi};
    assign fb      = bit_q ? FULL : -FULL;
    assign acc_nxt = acc + x_ext - fb;

    // Integrate sample minus fed-back bit, emit sign as the new bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr) begin
            acc   <= '0;
            bit_q <= 1'b0;
        end else if (stb) begin
            acc   <= acc_nxt;
            bit_q <= !acc_nxt[ACC_W-1];
        end
    end

    // R2: the loop stays bounded for any input in range
    a_r2_acc_range: assert property (@(posedge clk) disable iff (!rst_n)
        (acc >= -TWO_FULL) && (acc < TWO_FULL));

    // R2: after an update the bit matches the sign of the integrator
    a_r2_bit_sign: assert property (@(posedge clk) disable iff (!rst_n)
        en && !clr && stb |=> bit_q == (acc >= 0));

    // R5: a cleared loop restarts from zero state
    a_r5_dsm_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0) && !bit_q);
endmodule

// File: rtl/tbs_delay.sv
// Whole-bit data delay line with selectable tap.
// Assumes: dly < MAX_DLY; shifts once per bit boundary.
module tbs_delay #(
    parameter int MAX_DLY = 64,
    localparam int DLY_W  = $clog2(MAX_DLY)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             stb,
    input  logic             din,
    input  logic [DLY_W-1:0] dly,
    output logic             dout
);
    logic [MAX_DLY-2:0] line;

    assign dout = (dly == '0) ? din : line[dly - DLY_W'(1)];

    // Shift the newest finished bit into the line at each bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            line <= '0;
        end else if (stb) begin
            line <= {line[MAX_DLY-3:0], din};
        end
    end

    // R9: stored bits move only at bit boundaries
    a_r9_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
        en && !stb |=> $stable(line));
endmodule

// File: rtl/tbs_gen.sv
// Test bit-stream generator top: table playback, modulator, delay, clock phase.
// Assumes: sync is a single-cycle pulse; configuration changes only while en is low.
module tbs_gen
    import tbs_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int DEPTH    = 1024,
    parameter int MOD_W    = 16,
    parameter int HOLD_W   = 8,
    parameter int DIV_W    = 16,
    parameter int MAX_DLY  = 64,
    localparam int ADDR_W  = $clog2(DEPTH),
    localparam int DLY_W   = $clog2(MAX_DLY)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                sync,
    input  logic                sync_en,
    input  logic                loop_en,
    input  logic [PH_W-1:0]     clk_phase,
    input  logic [DLY_W-1:0]    data_dly,
    input  logic [DIV_W-1:0]    rate_div,
    input  logic [HOLD_W-1:0]   hold_m1,
    input  logic [ADDR_W-1:0]   tbl_last,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [SAMPLE_W-1:0] wr_data,
    output logic                bs_data,
    output logic                bs_clk,
    output logic                lb_data,
    output logic                lb_clk
);
    phase_t           phase;
    logic             bit_stb;
    logic             sync_clr;
    logic [MOD_W-1:0] sample_hi;
    logic             mod_bit;
    logic             stream;
    logic             clk_lvl;

    assign sync_clr = en && sync && sync_en;
    assign clk_lvl  = clk_level(phase, clk_phase);

    tbs_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .rate_div (rate_div),
        .phase    (phase),
        .bit_stb  (bit_stb)
    );

    tbs_table #(
        .SAMPLE_W (SAMPLE_W),
        .DEPTH    (DEPTH),
        .MOD_W    (MOD_W),
        .HOLD_W   (HOLD_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .bit_stb   (bit_stb),
        .sync_clr  (sync_clr),
        .tbl_last  (tbl_last),
        .hold_m1   (hold_m1),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sample_hi (sample_hi)
    );

    tbs_dsm #(.MOD_W(MOD_W)) u_dsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .clr       (sync_clr),
        .stb       (bit_stb),
        .sample_hi (sample_hi),
        .bit_q     (mod_bit)
    );

    tbs_delay #(.MAX_DLY(MAX_DLY)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .stb   (bit_stb),
        .din   (mod_bit),
        .dly   (data_dly),
        .dout  (stream)
    );

    // Register the stream and its clock onto the selected pin pair.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            bs_data <= 1'b0;
            bs_clk  <= 1'b0;
            lb_data <= 1'b0;
            lb_clk  <= 1'b0;
        end else begin
            bs_data <= !loop_en && stream;
            bs_clk  <= !loop_en && clk_lvl;
            lb_data <= loop_en && stream;
            lb_clk  <= loop_en && clk_lvl;
        end
    end

    // R1: a disabled block drives nothing
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !bs_data && !bs_clk && !lb_data && !lb_clk);

    // R10: loopback keeps the external pins low
    a_r10_ext_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |=> !bs_data && !bs_clk);

    // R10: external mode keeps the loopback lines low
    a_r10_loop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |=> !lb_data && !lb_clk);
endmodule

// File: tb/sim_tbs_gen.sv
// Directed bench for tbs_gen: one task per scenario, reference stream computed here.
module sim_tbs_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, sync = 1'b0, sync_en = 1'b0, loop_en = 1'b0;
    logic [2:0]  clk_phase = '0;
    logic [5:0]  data_dly = '0;
    logic [15:0] rate_div = '0;
    logic [7:0]  hold_m1 = '0;
    logic [9:0]  tbl_last = '0;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic        bs_data, bs_clk, lb_data, lb_clk;

    int ntests = 0, nfail = 0, cyc = 0, en_cyc = 0, other_hits = 0;
    bit done = 0;
    logic [23:0] shadow [0:15];
    logic got [0:255];
    int   rise_cyc [0:255];
    logic mdl [0:255];
    logic bref [0:255];

    tbs_gen u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .sync(sync), .sync_en(sync_en),
        .loop_en(loop_en), .clk_phase(clk_phase), .data_dly(data_dly),
        .rate_div(rate_div), .hold_m1(hold_m1), .tbl_last(tbl_last),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bs_data(bs_data), .bs_clk(bs_clk), .lb_data(lb_data), .lb_clk(lb_clk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_entry(input int a, input logic [23:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 10'(a); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        shadow[a] = v;
    endtask

    task automatic cfg(input int last, input int hold, input int rate, input int dly,
                       input int ofs, input bit sye, input bit lp);
        tbl_last = 10'(last); hold_m1 = 8'(hold); rate_div = 16'(rate);
        data_dly = 6'(dly); clk_phase = 3'(ofs); sync_en = sye; loop_en = lp;
    endtask

    task automatic restart();
        @(negedge clk); en = 1'b0;
        repeat (2) @(negedge clk);
        en = 1'b1; en_cyc = cyc;
    endtask

    // Record the data line at each rise of the selected bit clock.
    task automatic collect(input int n, input bit use_lb);
        logic prev, c, d;
        int j;
        prev = use_lb ? lb_clk : bs_clk;
        j = 0;
        other_hits = 0;
        while (j < n) begin
            @(negedge clk);
            c = use_lb ? lb_clk : bs_clk;
            d = use_lb ? lb_data : bs_data;
            if (use_lb ? (bs_clk | bs_data) : (lb_clk | lb_data)) other_hits++;
            if (c && !prev) begin
                got[j] = d; rise_cyc[j] = cyc; j++;
            end
            prev = c;
        end
    endtask

    // Reference stream from the stated modulator and pointer rules.
    task automatic build_model(input int last, input int hold, input int dly, input int n);
        int acc, x, fb, idx;
        logic y;
        acc = 0; y = 1'b0; bref[0] = 1'b0;
        for (int k = 1; k <= n; k++) begin
            idx = ((k - 1) / (hold + 1)) % (last + 1);
            x   = int'($signed(shadow[idx][23:8]));
            fb  = y ? 32768 : -32768;
            acc = acc + x - fb;
            y   = (acc >= 0);
            bref[k] = y;
        end
        for (int j = 0; j <= n; j++) mdl[j] = (j >= dly) ? bref[j - dly] : 1'b0;
    endtask

    task automatic compare(input int n, input int ofs, input string req, input string what);
        int mism;
        mism = 0;
        for (int j = 0; j < n; j++) if (got[j] !== mdl[j + ofs]) mism++;
        check(mism == 0, req, what, mism, 0);
    endtask

    task automatic t_reset();
        check(!bs_data && !bs_clk && !lb_data && !lb_clk, "R1", "outputs after reset",
              int'({bs_data, bs_clk, lb_data, lb_clk}), 0);
    endtask

    task automatic t_basic();
        write_entry(0, 24'h400000); write_entry(1, 24'h7FFFFF);
        write_entry(2, 24'hC00000); write_entry(3, 24'h800000);
        cfg(2, 0, 0, 0, 0, 0, 0);
        restart(); collect(48, 0);
        build_model(2, 0, 0, 60);
        compare(48, 0, "R4", "wrap at last entry stream mismatches");
        check(other_hits == 0, "R10", "loopback lines active in external mode", other_hits, 0);
        write_entry(0, 24'h800000);
        restart(); collect(48, 0);
        build_model(2, 0, 0, 60);
        compare(48, 0, "R11", "stream after table rewrite mismatches");
    endtask

    task automatic t_hold();
        cfg(3, 3, 2, 0, 0, 0, 0);
        restart(); collect(64, 0);
        build_model(3, 3, 0, 80);
        compare(64, 0, "R3", "held-entry stream mismatches");
        check(rise_cyc[10] - rise_cyc[9] == 24, "R7", "bit period in clocks",
              rise_cyc[10] - rise_cyc[9], 24);
    endtask

    task automatic t_shape();
        for (int i = 0; i < 16; i++) begin
            int v;
            v = (i < 8) ? (2 * i - 7) : (23 - 2 * i);
            write_entry(i, 24'(v * 524288));
        end
        cfg(15, 1, 0, 0, 0, 0, 0);
        restart(); collect(100, 0);
        build_model(15, 1, 0, 120);
        compare(100, 0, "R2", "triangle table stream mismatches");
    endtask

    task automatic t_delay();
        cfg(15, 1, 0, 5, 0, 0, 0);
        restart(); collect(100, 0);
        build_model(15, 1, 5, 120);
        compare(100, 0, "R9", "delay 5 stream mismatches");
        cfg(15, 1, 0, 63, 0, 0, 0);
        restart(); collect(120, 0);
        build_model(15, 1, 63, 130);
        compare(120, 0, "R9", "delay 63 stream mismatches");
    endtask

    task automatic t_phase();
        int base, r, sh;
        cfg(15, 1, 0, 0, 0, 0, 0);
        restart(); collect(4, 0);
        base = rise_cyc[3] - en_cyc;
        for (int p = 1; p < 8; p++) begin
            cfg(15, 1, 0, 0, p, 0, 0);
            restart(); collect(4, 0);
            r  = rise_cyc[3] - en_cyc;
            sh = (((r - base) % 8) + 8) % 8;
            check(sh == p, "R8", "clock rise shift in eighths", sh, p);
        end
    endtask

    task automatic t_sync();
        cfg(15, 0, 0, 0, 0, 1, 0);
        build_model(15, 0, 0, 60);
        restart(); collect(20, 0);
        sync = 1'b1;
        @(negedge clk); sync = 1'b0;
        collect(30, 0);
        compare(30, 1, "R5", "stream after allowed sync mismatches");
        cfg(15, 0, 0, 0, 0, 0, 0);
        restart(); collect(20, 0);
        sync = 1'b1;
        @(negedge clk); sync = 1'b0;
        collect(30, 0);
        compare(30, 20, "R6", "stream after masked sync mismatches");
    endtask

    task automatic t_loop();
        cfg(15, 1, 0, 0, 0, 0, 1);
        restart(); collect(40, 1);
        build_model(15, 1, 0, 50);
        compare(40, 0, "R10", "loopback stream mismatches");
        check(other_hits == 0, "R10", "external pins active in loopback", other_hits, 0);
    endtask

    task automatic t_idle();
        @(negedge clk); en = 1'b0;
        repeat (2) @(negedge clk);
        check(!bs_data && !bs_clk && !lb_data && !lb_clk, "R1", "outputs after disable",
              int'({bs_data, bs_clk, lb_data, lb_clk}), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_hold();
        t_shape();
        t_delay();
        t_phase();
        t_sync();
        t_loop();
        t_idle();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            ntests++; nfail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end
endmodule